// File: doc/BRIEF.md
# Dual-Gain Pedestal-Subtracted Optimal Filter

This block turns the digitized waveform of one calorimeter cell into two figures per pulse: an energy estimate and an energy-times-time estimate. Each bunch crossing it accepts one 14-bit code from a high-gain path and one from a low-gain path, taken at the same instant. The two paths together span a 16-bit dynamic range. Samples are grouped into back-to-back, non-overlapping windows of N samples (default 4). At the end of each window the block picks one gain for the whole window. It subtracts that gain's pedestal from every sample and runs two short FIR sums over the result, each with that gain's coefficient set. The rounded outputs leave on a valid/ready stream together with a gain tag.

Samples enter on a valid/ready stream. A sample is taken on any cycle where `in_valid` and `in_ready` are both high. While a result waits at the output with `out_ready` low, the whole pipeline freezes and `in_ready` drops. Once the result is taken, flow resumes without losing any sample. Pedestals and coefficients are written one word per cycle through a plain write strobe. Writes go to a staging copy, which is copied to the working copy as the last sample of a window is taken.

Top module: `dgof_filter`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. `out_valid` stays 0 until N samples have been accepted.
- R2: Accepted samples form consecutive, non-overlapping windows of N. Each window yields exactly one result, in order. Tap k applies to the k-th sample of the window, where tap 0 is the oldest.
- R3: The high gain is used (`out_gain`=0) unless some high-gain code in the window is at least 16000. In that case every sample of the window comes from the low gain, and `out_gain`=1.
- R4: Each sample of the chosen gain has that gain's pedestal subtracted. The difference is treated as a signed 15-bit value and may be negative.
- R5: `out_energy` = floor((sum of d_k*E_k + 128) / 256), saturated to the range -8388608..8388607. Here d_k are the differences from R4 and E_k are the energy coefficients of the chosen gain.
- R6: `out_etime` is formed in the same way as R5, using the time coefficient set of the chosen gain.
- R7: With the output free, `out_valid` rises 3 clock cycles after the edge that accepts the last sample of a window.
- R8: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_energy`, `out_etime` and `out_gain` hold their values, and `in_ready` is 0.
- R9: A write with `cfg_we`=1 is decoded as follows. `cfg_addr[4]` selects the gain (0 high, 1 low). `cfg_addr[3:2]` selects the item: 0 is an energy coefficient, 1 is a time coefficient, 2 is the pedestal (taken from `cfg_wdata[13:0]`), and 3 is ignored. `cfg_addr[1:0]` is the tap index. Coefficients are 18-bit signed.
- R10: A write applies to windows whose last sample is accepted in a later cycle. A window already accepted keeps the values it started with.
- R11: Sums beyond the 24-bit output range saturate, in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one sample per cycle at most |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample pair present |
| in_ready | output | 1 | Block can take a sample pair |
| in_hg | input | 14 | High-gain ADC code |
| in_lg | input | 14 | Low-gain ADC code |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration address (gain, item, tap) |
| cfg_wdata | input | 18 | Configuration write data |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_energy | output | 24 | Rounded energy sum, signed |
| out_etime | output | 24 | Rounded energy-times-time sum, signed |
| out_gain | output | 1 | 0 high gain, 1 low gain |

## Verification
The hardest situation to reach is a configuration write that lands while a window is only partly gathered, or while its result is still in the pipeline. This decides whether a result could mix old and new coefficients. The stimulus writes a coefficient between the third and fourth sample of one window, and again on the very cycle after the last sample of the next window is accepted. The first result must use the new value and the second must use the old one. The bench also stalls the output long enough to freeze a window mid-flight. It places high-gain codes at exactly 15999 and 16000 to pin the gain switch.

// File: rtl/dgof_pkg.sv
package dgof_pkg;
  // Item selector within a configuration address.
  typedef enum logic [1:0] {
    ITEM_ECOEF = 2'd0,
    ITEM_TCOEF = 2'd1,
    ITEM_PED   = 2'd2,
    ITEM_NONE  = 2'd3
  } cfg_item_e;
endpackage

// File: rtl/dgof_coef_bank.sv
module dgof_coef_bank #(
  parameter int N  = 4,
  parameter int SW = 14,
  parameter int CW = 18,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1,
  localparam int ADDRW = IDXW + 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [ADDRW-1:0]     cfg_addr,
  input  logic [CW-1:0]        cfg_wdata,
  input  logic                 commit,
  output logic signed [CW-1:0] act_e [2][N],
  output logic signed [CW-1:0] act_t [2][N],
  output logic [SW-1:0]        act_p [2]
);
  import dgof_pkg::*;

  logic signed [CW-1:0] stg_e [2][N];
  logic signed [CW-1:0] stg_t [2][N];
  logic [SW-1:0]        stg_p [2];

  logic            wg;
  cfg_item_e       witem;
  logic [IDXW-1:0] wtap;

  assign wg    = cfg_addr[ADDRW-1];
  assign witem = cfg_item_e'(cfg_addr[IDXW+1:IDXW]);
  assign wtap  = cfg_addr[IDXW-1:0];

  // Staging copy: written by software, one word at a time.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < 2; g++) begin
        stg_p[g] <= '0;
        for (int k = 0; k < N; k++) begin
          stg_e[g][k] <= '0;
          stg_t[g][k] <= '0;
        end
      end
    end else if (cfg_we) begin
      for (int k = 0; k < N; k++) begin
        if (wtap == IDXW'(k)) begin
          if (witem == ITEM_ECOEF) stg_e[wg][k] <= cfg_wdata;
          if (witem == ITEM_TCOEF) stg_t[wg][k] <= cfg_wdata;
        end
      end
      if (witem == ITEM_PED) stg_p[wg] <= cfg_wdata[SW-1:0];
    end
  end

  // Working copy: swapped atomically at a window boundary.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < 2; g++) begin
        act_p[g] <= '0;
        for (int k = 0; k < N; k++) begin
          act_e[g][k] <= '0;
          act_t[g][k] <= '0;
        end
      end
    end else if (commit) begin
      act_p <= stg_p;
      act_e <= stg_e;
      act_t <= stg_t;
    end
  end
endmodule

// File: rtl/dgof_window.sv
module dgof_window #(
  parameter int N   = 4,
  parameter int SW  = 14,
  parameter int SAT = 16000,
  localparam int DW = SW + 1,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 advance,
  input  logic                 in_valid,
  input  logic [SW-1:0]        in_hg,
  input  logic [SW-1:0]        in_lg,
  input  logic [SW-1:0]        act_p [2],
  output logic                 last_acc,
  output logic                 d_valid,
  output logic                 d_gain,
  output logic signed [DW-1:0] d_out [N]
);
  logic [SW-1:0]   hg_sr [N];
  logic [SW-1:0]   lg_sr [N];
  logic [IDXW-1:0] phase;
  logic            win_v;
  logic            accept;
  logic            any_sat;

  assign accept   = in_valid && advance;
  assign last_acc = accept && (phase == IDXW'(N - 1));

  // Shift register: index N-1 newest, index 0 oldest.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
      win_v <= 1'b0;
      for (int k = 0; k < N; k++) begin
        hg_sr[k] <= '0;
        lg_sr[k] <= '0;
      end
    end else if (advance) begin
      win_v <= last_acc;
      if (accept) begin
        phase <= last_acc ? '0 : phase + 1'b1;
        for (int k = 0; k < N - 1; k++) begin
          hg_sr[k] <= hg_sr[k+1];
          lg_sr[k] <= lg_sr[k+1];
        end
        hg_sr[N-1] <= in_hg;
        lg_sr[N-1] <= in_lg;
      end
    end
  end

  always_comb begin
    any_sat = 1'b0;
    for (int k = 0; k < N; k++)
      if (hg_sr[k] >= SW'(SAT)) any_sat = 1'b1;
  end

  // Gain choice and pedestal subtraction for the whole window.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_valid <= 1'b0;
      d_gain  <= 1'b0;
      for (int k = 0; k < N; k++) d_out[k] <= '0;
    end else if (advance) begin
      d_valid <= win_v;
      d_gain  <= any_sat;
      for (int k = 0; k < N; k++)
        d_out[k] <= $signed({1'b0, any_sat ? lg_sr[k] : hg_sr[k]})
                  - $signed({1'b0, act_p[any_sat]});
    end
  end
endmodule

// File: rtl/dgof_mac.sv
module dgof_mac #(
  parameter int N     = 4,
  parameter int DW    = 15,
  parameter int CW    = 18,
  parameter int OW    = 24,
  parameter int SHIFT = 8,
  localparam int AW = DW + CW + $clog2(N) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 advance,
  input  logic                 d_valid,
  input  logic                 d_gain,
  input  logic signed [DW-1:0] d_in [N],
  input  logic signed [CW-1:0] act_e [2][N],
  input  logic signed [CW-1:0] act_t [2][N],
  output logic                 out_valid,
  output logic                 out_gain,
  output logic signed [OW-1:0] out_energy,
  output logic signed [OW-1:0] out_etime
);
  localparam logic signed [AW:0] HALF = (AW+1)'(2 ** (SHIFT - 1));
  localparam logic signed [AW:0] MAXV = (AW+1)'((2 ** (OW - 1)) - 1);
  localparam logic signed [AW:0] MINV = -MAXV - 1;

  logic signed [AW-1:0] sum_e, sum_t, acc_e, acc_t;
  logic                 acc_v, acc_g;

  always_comb begin
    sum_e = '0;
    sum_t = '0;
    for (int k = 0; k < N; k++) begin
      sum_e = sum_e + AW'(d_in[k]) * AW'(act_e[d_gain][k]);
      sum_t = sum_t + AW'(d_in[k]) * AW'(act_t[d_gain][k]);
    end
  end

  function automatic logic signed [OW-1:0] round_sat(input logic signed [AW-1:0] a);
    logic signed [AW:0] t;
    t = ($signed({a[AW-1], a}) + HALF) >>> SHIFT;
    if (t > MAXV)      round_sat = MAXV[OW-1:0];
    else if (t < MINV) round_sat = MINV[OW-1:0];
    else               round_sat = t[OW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_v      <= 1'b0;
      acc_g      <= 1'b0;
      acc_e      <= '0;
      acc_t      <= '0;
      out_valid  <= 1'b0;
      out_gain   <= 1'b0;
      out_energy <= '0;
      out_etime  <= '0;
    end else if (advance) begin
      acc_v      <= d_valid;
      acc_g      <= d_gain;
      acc_e      <= sum_e;
      acc_t      <= sum_t;
      out_valid  <= acc_v;
      out_gain   <= acc_g;
      out_energy <= round_sat(acc_e);
      out_etime  <= round_sat(acc_t);
    end
  end
endmodule

// File: rtl/dgof_filter.sv
module dgof_filter #(
  parameter int N     = 4,
  parameter int SW    = 14,
  parameter int CW    = 18,
  parameter int OW    = 24,
  parameter int SHIFT = 8,
  parameter int SAT   = 16000,
  localparam int IDXW  = (N > 1) ? $clog2(N) : 1,
  localparam int ADDRW = IDXW + 3,
  localparam int DW    = SW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [SW-1:0]        in_hg,
  input  logic [SW-1:0]        in_lg,
  input  logic                 cfg_we,
  input  logic [ADDRW-1:0]     cfg_addr,
  input  logic [CW-1:0]        cfg_wdata,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [OW-1:0] out_energy,
  output logic signed [OW-1:0] out_etime,
  output logic                 out_gain
);
  logic                 advance, last_acc, d_valid, d_gain;
  logic signed [DW-1:0] d_vec [N];
  logic signed [CW-1:0] act_e [2][N];
  logic signed [CW-1:0] act_t [2][N];
  logic [SW-1:0]        act_p [2];

  // Global stall: the whole pipeline waits on a held result.
  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;

  dgof_coef_bank #(.N(N), .SW(SW), .CW(CW)) u_bank (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .commit(last_acc),
    .act_e(act_e), .act_t(act_t), .act_p(act_p)
  );

  dgof_window #(.N(N), .SW(SW), .SAT(SAT)) u_win (
    .clk(clk), .rst_n(rst_n), .advance(advance), .in_valid(in_valid),
    .in_hg(in_hg), .in_lg(in_lg), .act_p(act_p), .last_acc(last_acc),
    .d_valid(d_valid), .d_gain(d_gain), .d_out(d_vec)
  );

  dgof_mac #(.N(N), .DW(DW), .CW(CW), .OW(OW), .SHIFT(SHIFT)) u_mac (
    .clk(clk), .rst_n(rst_n), .advance(advance), .d_valid(d_valid),
    .d_gain(d_gain), .d_in(d_vec), .act_e(act_e), .act_t(act_t),
    .out_valid(out_valid), .out_gain(out_gain),
    .out_energy(out_energy), .out_etime(out_etime)
  );
endmodule

// File: rtl/dgof_filter_chk.sv
module dgof_filter_chk #(
  parameter int N  = 4,
  parameter int OW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [OW-1:0] out_energy,
  input logic [OW-1:0] out_etime,
  input logic          out_gain
);
  int unsigned n_acc, n_win, n_out;
  logic        last_seen;

  assign last_seen = in_valid && in_ready && (n_acc % N == N - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_acc <= 0;
      n_win <= 0;
      n_out <= 0;
    end else begin
      if (in_valid && in_ready) n_acc <= n_acc + 1;
      if (last_seen) n_win <= n_win + 1;
      if (out_valid && out_ready) n_out <= n_out + 1;
    end
  end

  // R1: nothing leaves before a full window has been taken.
  p_quiet_fill_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (n_acc >= N));

  // R2: never more results than completed windows.
  p_one_per_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (n_win > n_out));

  // R7: an unstalled result appears exactly 3 cycles after its last sample.
  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_valid) && $past(in_ready, 1) && $past(in_ready, 2) && $past(in_ready, 3))
      |-> $past(last_seen, 4));

  // R8: a held result does not change.
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_energy)
      && $stable(out_etime) && $stable(out_gain)));
endmodule

bind dgof_filter dgof_filter_chk #(.N(N), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_energy(out_energy),
  .out_etime(out_etime), .out_gain(out_gain)
);

// File: tb/dgof_filter_tb.sv
module dgof_filter_tb;
  localparam int N = 4;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready;
  logic [13:0] in_hg = 0, in_lg = 0;
  logic cfg_we = 0;
  logic [4:0] cfg_addr = 0;
  logic [17:0] cfg_wdata = 0;
  logic out_valid, out_ready = 1, out_gain;
  logic signed [23:0] out_energy, out_etime;

  always #5 clk = ~clk;

  dgof_filter u_dut (.*);

  int total = 0, bad = 0;
  typedef struct { longint e; longint t; int g; } res_t;
  res_t q[$];

  // Model state
  int sh_e[2][N], sh_t[2][N], sh_p[2];
  int ac_e[2][N], ac_t[2][N], ac_p[2];
  int wh[N], wl[N];
  int widx = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic longint rsat(input longint a);
    longint t;
    t = (a + 128) >>> 8;
    if (t > 8388607) t = 8388607;
    if (t < -8388608) t = -8388608;
    return t;
  endfunction

  function automatic void close_window();
    res_t r;
    longint se = 0, st = 0, d;
    int g = 0;
    ac_e = sh_e; ac_t = sh_t; ac_p = sh_p;
    for (int k = 0; k < N; k++) if (wh[k] >= 16000) g = 1;
    for (int k = 0; k < N; k++) begin
      d = longint'(g ? wl[k] : wh[k]) - ac_p[g];
      se += d * ac_e[g][k];
      st += d * ac_t[g][k];
    end
    r.e = rsat(se); r.t = rsat(st); r.g = g;
    q.push_back(r);
  endfunction

  // Driver: call aligned 1 ns after a rising edge.
  task automatic push(input int h, input int l);
    bit rdy;
    in_hg = 14'(h); in_lg = 14'(l); in_valid = 1;
    forever begin
      @(negedge clk); rdy = in_ready;
      @(posedge clk);
      if (rdy) break;
    end
    wh[widx] = h; wl[widx] = l;
    if (widx == N - 1) begin close_window(); widx = 0; end
    else widx++;
    #1 in_valid = 0;
  endtask

  task automatic wr(input int g, input int item, input int tap, input int v);
    cfg_we = 1; cfg_addr = 5'((g << 4) | (item << 2) | tap); cfg_wdata = 18'(v);
    @(posedge clk);
    if (item == 0) sh_e[g][tap] = v;
    if (item == 1) sh_t[g][tap] = v;
    if (item == 2) sh_p[g] = v & 16'h3fff;
    #1 cfg_we = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      res_t r;
      if (q.size() == 0) check(0, "R2 unexpected result", 1, 0);
      else begin
        r = q.pop_front();
        check(out_energy == r.e, "R5 energy", out_energy, r.e);
        check(out_etime == r.t, "R6 etime", out_etime, r.t);
        check(out_gain == r.g, "R3 gain", out_gain, r.g);
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  int unsigned seed = 32'h1234;
  function automatic int rnd14();
    seed = seed * 1103515245 + 12345;
    return int'((seed >> 8) % 16384);
  endfunction

  initial begin
    logic signed [23:0] held;
    for (int g = 0; g < 2; g++) begin
      sh_p[g] = 0;
      for (int k = 0; k < N; k++) begin sh_e[g][k] = 0; sh_t[g][k] = 0; end
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
    check(in_ready == 1, "R1 in_ready after reset", in_ready, 1);
    @(posedge clk); #1;

    // R9: configure both gains
    wr(0, 2, 0, 1000); wr(1, 2, 0, 50);
    for (int k = 0; k < N; k++) begin
      wr(0, 0, k, 64 * (k + 1));
      wr(0, 1, k, -300 + 200 * k);
      wr(1, 0, k, 2000 - 300 * k);
      wr(1, 1, k, 77 * k - 100);
    end
    wr(0, 3, 1, 99999); // R9: item 3 ignored

    // R1: partial window stays silent
    for (int k = 0; k < N - 1; k++) push(1100 + k, 60 + k);
    idle(6);
    @(negedge clk);
    check(out_valid == 0, "R1 no output before N samples", out_valid, 0);
    @(posedge clk); #1;
    push(1500, 70);
    // R7: accept edge E; valid first seen at 4th negedge after E
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(out_valid == 0, "R7 early valid", out_valid, 0);
    end
    @(negedge clk);
    check(out_valid == 1, "R7 valid at 3 cycles", out_valid, 1);
    @(posedge clk); #1;

    // R2/R4/R5/R6: varied windows, back to back
    for (int w = 0; w < 12; w++)
      for (int k = 0; k < N; k++) push(rnd14() % 15000, rnd14());

    // R4: samples below pedestal
    for (int k = 0; k < N; k++) push(10 * k, 5);

    // R3: gain boundary
    push(15999, 9000); push(15999, 9001); push(15999, 9002); push(15999, 9003);
    push(2000, 100); push(16000, 200); push(3000, 300); push(4000, 400);
    idle(6);

    // R10: write mid-window applies; write after last sample does not
    push(1200, 10); push(1300, 20); push(1400, 30);
    wr(0, 0, 3, 5000);
    push(1500, 40);
    push(1200, 10); push(1300, 20); push(1400, 30); push(1500, 40);
    wr(0, 0, 0, -7000);
    idle(6);
    push(1200, 10); push(1300, 20); push(1400, 30); push(1500, 40);
    idle(6);

    // R11: saturation both ways
    wr(0, 2, 0, 0);
    for (int k = 0; k < N; k++) begin wr(0, 0, k, 131071); wr(0, 1, k, -131072); end
    for (int k = 0; k < N; k++) push(15999, 0);
    idle(6);

    // R8: back-pressure
    out_ready = 0;
    fork
      begin
        for (int k = 0; k < 2 * N; k++) push(rnd14() % 15000, rnd14());
      end
      begin
        idle(8);
        @(negedge clk);
        check(out_valid == 1, "R8 result waiting", out_valid, 1);
        check(in_ready == 0, "R8 in_ready low under stall", in_ready, 0);
        held = out_energy;
        repeat (4) @(negedge clk);
        check(out_energy == held, "R8 energy held", out_energy, held);
        check(out_valid == 1, "R8 valid held", out_valid, 1);
        @(posedge clk); #1;
        out_ready = 1;
      end
    join
    idle(10);
    check(q.size() == 0, "R2 all results delivered", q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule